// File: doc/BRIEF.md
# Write completion poller

This block runs on the host side of a flash memory and works out when an internal program or erase has finished. Once the write strobe that starts the internal operation has been issued, software or a sequencer hands the poller one start command. The command carries a detection mode, the address that was written and the byte the location should hold once the write is over. The poller then reads that location again and again through a simple request/response read port and decides from each returned byte whether the part is still busy.

Two detection methods are offered. Data polling watches bit 7, which reads as the complement of the expected bit 7 while the part is busy. Toggle detection watches bit 6, which flips on every read while the part is busy. The end of the write is asynchronous to the host, so a single read can catch the part at the moment it finishes and return a byte that is half status and half data. To guard against this, a byte that looks settled but does not equal the expected value is never trusted on its own. The poller reads the location exactly two more times. It reports success only if both of those reads return the expected byte, and otherwise it reports failure. A cycle limit turns a write that never finishes into a timeout.

The start port and the read-request port are valid/ready. The start port is back-pressured (`start_ready` low) for the whole operation. A read request is held stable until the memory side takes it. The response side offers `rd_rsp_ready` only while one read is outstanding. Results are single-cycle pulses.

Top module: `wr_status_poller`

## Requirements
- R1: After reset, `start_ready` is 1, and `rd_req_valid`, `done`, `fail` and `timeout` are 0.
- R2: A start is taken on a clock edge where `start_valid` and `start_ready` are both 1. From that edge until the result pulse, `start_ready` stays 0, and any start offered in that time has no effect on the running operation or its read address.
- R3: `rd_req_addr` always equals the captured start address. Once raised, `rd_req_valid` stays 1 with a stable address until `rd_req_ready` is 1 on an edge. Only one read is outstanding at a time, and its response is taken on an edge where `rd_rsp_valid` and `rd_rsp_ready` are both 1.
- R4: With `start_mode` = 0 (data polling), a returned byte counts as settled when its bit 7 equals bit 7 of the expected byte. Otherwise the location is read again.
- R5: With `start_mode` = 1 (toggle), a returned byte counts as settled when its bit 6 equals bit 6 of the previous read in the same operation. The first read of an operation is never settled.
- R6: A settled byte equal to the expected byte in all 8 bits produces a `done` pulse.
- R7: A settled byte that differs from the expected byte triggers exactly two further reads. `done` follows if both of them equal the expected byte; otherwise `fail` follows.
- R8: `cfg_limit` is captured at the start edge. If no result has been produced, `timeout` pulses in the cycle that follows the edge `cfg_limit`+1 clock cycles after the start edge.
- R9: `done`, `fail` and `timeout` are one cycle wide and never high together, and `start_ready` is 1 in the same cycle as the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start command offered |
| start_ready | output | 1 | Poller idle, start can be taken |
| start_mode | input | 1 | 0 = data polling on bit 7, 1 = toggle on bit 6 |
| start_addr | input | AW | Location to poll |
| start_exp | input | DW | Byte the location holds after a good write |
| cfg_limit | input | CW | Cycle budget before timeout |
| rd_req_valid | output | 1 | Read request pending |
| rd_req_ready | input | 1 | Memory side takes the request |
| rd_req_addr | output | AW | Read address |
| rd_rsp_valid | input | 1 | Read data present |
| rd_rsp_ready | output | 1 | Poller waiting for read data |
| rd_rsp_data | input | DW | Returned byte |
| done | output | 1 | Write completed (pulse) |
| fail | output | 1 | Write rejected after confirmation (pulse) |
| timeout | output | 1 | Cycle budget exhausted (pulse) |

## Verification
The bench aims at the read that lands on the completion instant and returns a settled-looking but wrong byte. A design that trusted that read would pulse `fail` on a good write, and one that skipped the confirmation would accept a truly bad byte. A design that counted the confirmation reads wrongly would decide after one read or three. In toggle mode, the bench checks that the first read cannot count as settled and that a real data mismatch still ends in `fail`. The timeout is checked to the exact cycle, which catches an off-by-one in the budget. Stalled read requests and starts offered while busy are checked for a moving address or a hijacked operation.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;
  typedef enum logic {MD_DATA = 1'b0, MD_TOGGLE = 1'b1} mode_e;
  typedef enum logic [1:0] {EV_BUSY, EV_MATCH, EV_SUSPECT} verdict_e;
endpackage

// File: rtl/wsp_eval.sv
// Classifies one returned byte: still busy, settled and matching, or settled but suspect.
module wsp_eval #(
  parameter int DW       = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  wsp_pkg::mode_e    mode,
  input  logic [DW-1:0]     rd_data,
  input  logic [DW-1:0]     exp_data,
  input  logic              prev_tog,
  input  logic              have_prev,
  output wsp_pkg::verdict_e verdict,
  output logic              match
);
  import wsp_pkg::*;
  logic stopped;

  always_comb begin
    if (mode == MD_DATA) stopped = (rd_data[POLL_BIT] == exp_data[POLL_BIT]);
    else                 stopped = have_prev && (rd_data[TOG_BIT] == prev_tog);
    match = (rd_data == exp_data);
    if (!stopped)   verdict = EV_BUSY;
    else if (match) verdict = EV_MATCH;
    else            verdict = EV_SUSPECT;
  end
endmodule

// File: rtl/wsp_timer.sv
// Cycle budget: counts busy cycles from the start edge, flags when the limit is reached.
module wsp_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          run,
  input  logic [CW-1:0] limit_in,
  output logic          expired
);
  logic [CW-1:0] cnt_q, lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (capture) begin
      cnt_q <= '0;
      lim_q <= limit_in;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && (cnt_q == lim_q);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= lim_q); // R8
endmodule

// File: rtl/wr_status_poller.sv
module wr_status_poller #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int CW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic          start_mode,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_exp,
  input  logic [CW-1:0] cfg_limit,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          done,
  output logic          fail,
  output logic          timeout
);
  import wsp_pkg::*;

  localparam int CONF_READS = 2;
  localparam int CFW        = $clog2(CONF_READS + 1);

  st_e            st_q;
  mode_e          mode_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  exp_q;
  logic           prev_q, have_prev_q;
  logic [CFW-1:0] conf_left_q;
  logic           conf_ok_q;
  logic           done_q, fail_q, to_q;

  verdict_e verdict;
  logic     match, expired;
  logic     accept, rsp_take, res_done, res_fail, tmo;

  assign start_ready  = (st_q == ST_IDLE);
  assign rd_req_valid = (st_q == ST_ISSUE);
  assign rd_rsp_ready = (st_q == ST_WAIT);
  assign rd_req_addr  = addr_q;
  assign done         = done_q;
  assign fail         = fail_q;
  assign timeout      = to_q;
  assign accept       = start_valid && start_ready;
  assign rsp_take     = rd_rsp_valid && rd_rsp_ready;

  wsp_eval #(.DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_eval (
    .mode     (mode_q),
    .rd_data  (rd_rsp_data),
    .exp_data (exp_q),
    .prev_tog (prev_q),
    .have_prev(have_prev_q),
    .verdict  (verdict),
    .match    (match)
  );

  wsp_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (accept),
    .run     (st_q != ST_IDLE),
    .limit_in(cfg_limit),
    .expired (expired)
  );

  // A result decided on this edge beats an expiring budget.
  always_comb begin
    res_done = 1'b0;
    res_fail = 1'b0;
    if (rsp_take) begin
      if (conf_left_q == '0) begin
        res_done = (verdict == EV_MATCH);
      end else if (conf_left_q == CFW'(1)) begin
        res_done = conf_ok_q && match;
        res_fail = !(conf_ok_q && match);
      end
    end
    tmo = expired && !res_done && !res_fail;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      mode_q      <= MD_DATA;
      addr_q      <= '0;
      exp_q       <= '0;
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
      conf_left_q <= '0;
      conf_ok_q   <= 1'b1;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
      to_q        <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      to_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          mode_q      <= mode_e'(start_mode);
          addr_q      <= start_addr;
          exp_q       <= start_exp;
          have_prev_q <= 1'b0;
          conf_left_q <= '0;
          conf_ok_q   <= 1'b1;
          st_q        <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (tmo) begin
            to_q <= 1'b1;
            st_q <= ST_IDLE;
          end else if (rd_req_ready) begin
            st_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (res_done) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (res_fail) begin
            fail_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (tmo) begin
            to_q <= 1'b1;
            st_q <= ST_IDLE;
          end else if (rsp_take) begin
            prev_q      <= rd_rsp_data[TOG_BIT];
            have_prev_q <= 1'b1;
            if (conf_left_q == '0) begin
              if (verdict == EV_SUSPECT) begin
                conf_left_q <= CFW'(CONF_READS);
                conf_ok_q   <= 1'b1;
              end
            end else begin
              conf_left_q <= conf_left_q - 1'b1;
              conf_ok_q   <= conf_ok_q && match;
            end
            st_q <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, fail, timeout}) <= 1); // R9
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail || timeout) |=> !(done || fail || timeout)); // R9
  AST_IDLE_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail || timeout) |-> start_ready); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> ((rd_req_valid && $stable(rd_req_addr)) || timeout)); // R3
  AST_BUSY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ready |=> $stable(rd_req_addr)); // R2
  AST_CONFIRM_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $past(conf_left_q) == CFW'(1)); // R7
endmodule

// File: tb/wr_status_poller_tb.sv
module wr_status_poller_tb;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic          start_mode = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] start_exp = '0;
  logic [CW-1:0] cfg_limit = '0;
  logic          rd_req_valid;
  logic          rd_req_ready = 1'b1;
  logic [AW-1:0] rd_req_addr;
  logic          rd_rsp_valid;
  logic          rd_rsp_ready;
  logic [DW-1:0] rd_rsp_data;
  logic          done, fail, timeout;

  int checks = 0;
  int failures = 0;

  // memory model state
  logic          mdl_clr = 1'b0;
  logic          cur_mode = 1'b0;
  logic [7:0]    cur_exp = '0;
  logic [15:0]   cur_busy = '0;
  logic          cur_race = 1'b0;
  logic [7:0]    cur_final = '0;
  logic [AW-1:0] cur_addr = '0;
  logic          rsp_v;
  logic [7:0]    rsp_d;
  int            nrd;
  int            addr_err;

  assign rd_rsp_valid = rsp_v;
  assign rd_rsp_data  = rsp_d;

  always #10 clk = ~clk;

  wr_status_poller #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready), .start_mode(start_mode),
    .start_addr(start_addr), .start_exp(start_exp), .cfg_limit(cfg_limit),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .done(done), .fail(fail), .timeout(timeout)
  );

  // Byte seen by read number i: busy status, then optionally one torn read, then final data.
  function automatic logic [7:0] mem_byte(int i);
    if (i < int'(cur_busy))
      return {~cur_exp[7], i[0], 6'b0};
    if (cur_race && i == int'(cur_busy)) begin
      if (cur_mode == 1'b0) return {cur_exp[7], ~cur_exp[6:0]};
      return {cur_exp[7], ~cur_busy[0], ~cur_exp[5:0]};
    end
    return cur_final;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || mdl_clr) begin
      rsp_v    <= 1'b0;
      rsp_d    <= '0;
      nrd      <= 0;
      addr_err <= 0;
    end else begin
      if (rsp_v && rd_rsp_ready) rsp_v <= 1'b0;
      if (rd_req_valid && rd_req_ready) begin
        rsp_v <= 1'b1;
        rsp_d <= mem_byte(nrd);
        nrd   <= nrd + 1;
        if (rd_req_addr != cur_addr) addr_err <= addr_err + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic do_start(input logic md, input logic [AW-1:0] ad, input logic [7:0] ex,
                          input logic [15:0] bz, input logic rc, input logic [7:0] fn,
                          input logic [CW-1:0] lim);
    cur_mode = md; cur_exp = ex; cur_busy = bz; cur_race = rc; cur_final = fn; cur_addr = ad;
    start_mode = md; start_addr = ad; start_exp = ex; cfg_limit = lim;
    start_valid = 1'b1;
    mdl_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    mdl_clr = 1'b0;
  endtask

  // outcome: 0 done, 1 fail, 2 timeout
  task automatic wait_result(input int lim, input int outcome, input string req);
    int j = 0;
    int got = 3;
    while (j < 5000) begin
      @(posedge clk);
      j++;
      @(negedge clk);
      if (done || fail || timeout) break;
    end
    if (done) got = 0;
    else if (fail) got = 1;
    else if (timeout) got = 2;
    chk(got == outcome, req, "outcome", got, outcome);
    chk($countones({done, fail, timeout}) == 1, "R9", "single result", $countones({done, fail, timeout}), 1);
    chk(start_ready == 1'b1, "R9", "ready with pulse", int'(start_ready), 1);
    chk(addr_err == 0, "R3", "read address", addr_err, 0);
    if (outcome == 2) chk(j == lim + 1, "R8", "timeout cycle", j, lim + 1);
    @(posedge clk);
    @(negedge clk);
    chk(!(done || fail || timeout), "R9", "pulse width", int'({done, fail, timeout}), 0);
  endtask

  // {mode, exp[8], busy[16], race, final[8], limit[16], outcome[2]}
  localparam int NV = 9;
  localparam logic [51:0] VEC [NV] = '{
    {1'b0, 8'hA5, 16'd3,    1'b0, 8'hA5, 16'd200, 2'd0},  // R4 R6 poll, busy then good
    {1'b0, 8'h3C, 16'd0,    1'b0, 8'h3C, 16'd200, 2'd0},  // R6 poll, done at once
    {1'b0, 8'h5A, 16'd2,    1'b1, 8'h5A, 16'd200, 2'd0},  // R7 poll, torn read confirmed good
    {1'b0, 8'h81, 16'd1,    1'b0, 8'h80, 16'd200, 2'd1},  // R7 poll, real mismatch
    {1'b1, 8'h77, 16'd4,    1'b0, 8'h77, 16'd200, 2'd0},  // R5 R6 toggle, good
    {1'b1, 8'h12, 16'd3,    1'b1, 8'h12, 16'd200, 2'd0},  // R5 R7 toggle, torn read
    {1'b1, 8'hF0, 16'd2,    1'b0, 8'hE0, 16'd200, 2'd1},  // R7 toggle, real mismatch
    {1'b0, 8'h80, 16'd0,    1'b0, 8'h00, 16'd20,  2'd2},  // R4 R8 poll never settles
    {1'b1, 8'h55, 16'd1000, 1'b0, 8'h55, 16'd30,  2'd2}   // R5 R8 toggle never settles
  };
  localparam string VREQ [NV] = '{"R4", "R6", "R7", "R7", "R5", "R7", "R7", "R4", "R5"};

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(start_ready == 1'b1, "R1", "start_ready", int'(start_ready), 1);
    chk(rd_req_valid == 1'b0, "R1", "rd_req_valid", int'(rd_req_valid), 0);
    chk({done, fail, timeout} == 3'b000, "R1", "results", int'({done, fail, timeout}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_ready == 1'b1 && rd_req_valid == 1'b0, "R1", "idle after reset",
        int'({start_ready, rd_req_valid}), 2);

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      v = VEC[i];
      do_start(v[51], AW'(i * 37 + 5), v[50:43], v[42:27], v[26], v[25:18], v[17:2]);
      wait_result(int'(v[17:2]), int'(v[1:0]), VREQ[i]);
    end

    // R2: starts offered while busy are ignored
    do_start(1'b1, 16'h1234, 8'h6B, 16'd6, 1'b0, 8'h6B, 16'd300);
    start_valid = 1'b1;
    start_mode = 1'b0;
    start_addr = 16'hBEEF;
    start_exp = 8'h00;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(start_ready == 1'b0, "R2", "busy back-pressure", int'(start_ready), 0);
    end
    start_valid = 1'b0;
    chk(rd_req_addr == 16'h1234, "R2", "address kept", int'(rd_req_addr), 16'h1234);
    wait_result(300, 0, "R2");

    // R3: stalled read request stays valid with a stable address
    rd_req_ready = 1'b0;
    do_start(1'b0, 16'h0F0F, 8'hC3, 16'd0, 1'b0, 8'hC3, 16'd300);
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(rd_req_valid == 1'b1 && rd_req_addr == 16'h0F0F, "R3", "stalled request",
          int'(rd_req_addr), 16'h0F0F);
    end
    rd_req_ready = 1'b1;
    wait_result(300, 0, "R3");

    // R8: zero budget times out on the first edge after the start edge
    do_start(1'b0, 16'h0001, 8'h80, 16'd0, 1'b0, 8'h00, 16'd0);
    wait_result(0, 2, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule